// File: doc/BRIEF.md
# Odd-Times-Power-of-Two Tick Prescaler

This block turns the system clock into a slow, single-cycle tick enable for bit-timing logic. Typical use is a bit-timing engine that needs a tick near 1 MHz. Software writes one 8-bit control byte. That byte holds an enable bit and two divide fields. The first field picks an odd factor of 1, 3, 5 or 7. The second picks a power of two from 1 to 128. The tick period in system-clock cycles is the product of the two.

The output is a clock enable, not a derived clock. Every consumer stays on the system clock and qualifies its updates with the tick. Internally there are two cascaded counters. The odd stage wraps every 2P+1 cycles. The power-of-two stage counts those wraps and fires on the last one of each group of 2^D.

A write to the control byte restarts both stages from zero, so the tick phase is known after every write. A cleared enable bit holds both stages at zero and no tick is issued.

Top module: `prescale_tick_gen`

## Requirements
- R1: A synchronous reset clears the control byte to 0x00, and the tick stays low until an enabling value is written.
- R2: While bit 7 (enable) of the control byte is 0, the tick stays low.
- R3: Bits [1:0] hold P, and the odd stage divides by 2P+1, giving a factor of 1, 3, 5 or 7.
- R4: Bits [4:2] hold D, and the power-of-two stage divides further by 2^D. The tick period is N = (2P+1)·2^D cycles.
- R5: With the block enabled and N > 1, the tick is high for exactly one cycle out of every N. With N = 1, the tick is high in every cycle.
- R6: A write is sampled on a clock edge, and that edge restarts both stages from zero. The first tick after the write is high in the N-th cycle following that edge, and further ticks follow every N cycles.
- R7: Bits [6:5] of the control byte have no effect on the tick. For example, 0xE1 behaves exactly like 0x81.
- R8: The following settings give these periods: 0x80 gives 1, 0x81 gives 3, 0x8C gives 8, 0x9C gives 128 and 0x9F gives 896.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control byte; it also restarts the counters |
| cfg_wdata | input | 8 | Control byte: [7] enable, [6:5] unused, [4:2] D, [1:0] P |
| tick | output | 1 | One-cycle tick enable, once every N cycles |

## Verification
A wrong count in either stage shows up as a tick that comes early or late relative to the last write edge. This error is visible within one period of N cycles, so the bench compares the tick cycle by cycle over two full periods after each write. A stage that fails to clear on a write shifts the first tick. This shift is caught at the first expected tick position after the restart. A stuck enable or a leaking unused bit shows up in the very first window as a missing tick or a spurious one.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

    localparam int unsigned CFG_W     = 8;
    localparam int unsigned ODD_SEL_W = 2;
    localparam int unsigned POW_SEL_W = 3;
    localparam int unsigned SPARE_W   = CFG_W - 1 - POW_SEL_W - ODD_SEL_W;
    localparam int unsigned ODD_CNT_W = ODD_SEL_W + 1;
    localparam int unsigned POW_CNT_W = (1 << POW_SEL_W) - 1;

    // Field layout of the control byte (MSB first).
    typedef struct packed {
        logic                 enable;
        logic [SPARE_W-1:0]   spare;
        logic [POW_SEL_W-1:0] pow_sel;
        logic [ODD_SEL_W-1:0] odd_sel;
    } prescale_cfg_t;

    // Terminal count of the odd stage: 2P.
    function automatic logic [ODD_CNT_W-1:0] odd_last(input logic [ODD_SEL_W-1:0] p);
        return {p, 1'b0};
    endfunction

    // Terminal count of the power-of-two stage: 2^D - 1.
    function automatic logic [POW_CNT_W-1:0] pow_last(input logic [POW_SEL_W-1:0] d);
        return ~({POW_CNT_W{1'b1}} << d);
    endfunction

    // Full tick period in system-clock cycles.
    function automatic int unsigned ratio_of(input prescale_cfg_t c);
        return (2 * int'(c.odd_sel) + 1) << c.pow_sel;
    endfunction

endpackage

// File: rtl/prescale_cfg_reg.sv
module prescale_cfg_reg
    import prescale_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output prescale_cfg_t    cfg_q,
    output logic             restart
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= prescale_cfg_t'(wr_data);
    end

    // A write restarts both stages on the same edge that loads the byte.
    assign restart = wr_en;
endmodule

// File: rtl/prescale_odd_stage.sv
module prescale_odd_stage #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] last,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt;

    assign wrap = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clear || !run)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/prescale_pow2_stage.sv
module prescale_pow2_stage #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] last,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt;

    assign wrap = run && step && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clear || !run)
            cnt <= '0;
        else if (step)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/prescale_tick_gen.sv
module prescale_tick_gen
    import prescale_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             tick
);
    prescale_cfg_t cfg_q;
    logic          restart;
    logic          odd_wrap;
    logic          pow_wrap;

    prescale_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg_q),
        .restart (restart)
    );

    prescale_odd_stage #(.CNT_W(ODD_CNT_W)) u_odd (
        .clk   (clk),
        .rst   (rst),
        .clear (restart),
        .run   (cfg_q.enable),
        .last  (odd_last(cfg_q.odd_sel)),
        .wrap  (odd_wrap)
    );

    prescale_pow2_stage #(.CNT_W(POW_CNT_W)) u_pow (
        .clk   (clk),
        .rst   (rst),
        .clear (restart),
        .run   (cfg_q.enable),
        .step  (odd_wrap),
        .last  (pow_last(cfg_q.pow_sel)),
        .wrap  (pow_wrap)
    );

    assign tick = pow_wrap;
endmodule

// File: rtl/prescale_tick_gen_chk.sv
module prescale_tick_gen_chk
    import prescale_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input prescale_cfg_t    cfg_q,
    input logic             tick
);
    // Cycles since the last tick or restart, saturating.
    logic [11:0] gap;

    always_ff @(posedge clk) begin
        if (rst || cfg_we || tick)
            gap <= '0;
        else if (gap != '1)
            gap <= gap + 1'b1;
    end

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.enable |-> !tick);

    assert_period_R5: assert property (@(posedge clk) disable iff (rst)
        tick |-> (32'(gap) == ratio_of(cfg_q) - 1));

    assert_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !cfg_we && (cfg_q.pow_sel != 0 || cfg_q.odd_sel != 0)) |=> !tick);

    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (tick == (cfg_wdata[7] && cfg_wdata[4:0] == 5'd0)));

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !tick);
endmodule

bind prescale_tick_gen prescale_tick_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .tick      (tick)
);

// File: tb/prescale_tick_gen_test.sv
module prescale_tick_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       tick;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    prescale_tick_gen uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tick      (tick)
    );

    always #2 clk = ~clk;

    localparam int NV = 11;
    localparam logic [7:0] VEC [NV] = '{
        8'h80,  // R8 period 1
        8'h81,  // R8 period 3
        8'h82,  // R3 period 5
        8'h83,  // R3 period 7
        8'h84,  // R4 period 2
        8'h8C,  // R8 period 8
        8'h9C,  // R8 period 128
        8'h9F,  // R8 period 896
        8'hE1,  // R7 unused bits set, period 3
        8'h00,  // R2 disabled
        8'h1F   // R2 disabled with fields set
    };

    function automatic int period_of(input logic [7:0] v);
        return (2 * int'(v[1:0]) + 1) * (1 << v[4:2]);
    endfunction

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Called at the negedge right after the write edge; compares cycle by cycle.
    task automatic check_window(input logic [7:0] v, input int len, input string tag);
        int  n = period_of(v);
        bit  bad = 0;
        for (int i = 0; i < len; i++) begin
            logic exp = v[7] && ((i % n) == n - 1);
            if (!bad && tick !== exp) begin
                bad = 1;
                $display("FAIL %s cfg=%02h cycle %0d: tick actual %b expected %b", tag, v, i, tick, exp);
            end
            @(negedge clk);
        end
        n_chk++;
        if (bad) n_bad++;
    endtask

    task automatic check_low(input int len, input string tag);
        bit bad = 0;
        for (int i = 0; i < len; i++) begin
            if (!bad && tick !== 1'b0) begin
                bad = 1;
                $display("FAIL %s cycle %0d: tick actual %b expected 0", tag, i, tick);
            end
            @(negedge clk);
        end
        n_chk++;
        if (bad) n_bad++;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: tick low during and after reset with no write
        check_low(2, "R1 in reset");
        rst = 1'b0;
        check_low(10, "R1 after reset");

        // Table walk: R3 R4 R5 R6 R7 R8 R2
        for (int k = 0; k < NV; k++) begin
            write_cfg(VEC[k]);
            check_window(VEC[k], VEC[k][7] ? 2 * period_of(VEC[k]) + 3 : 40,
                         "R3 R4 R5 R6 R7 R8 R2 table");
        end

        // R6: rewrite mid-period restarts the phase
        write_cfg(8'h83);
        repeat (4) @(negedge clk);
        write_cfg(8'h83);
        check_window(8'h83, 17, "R6 restart mid-period");

        // R6: switching period mid-run restarts with the new period
        write_cfg(8'h8C);
        repeat (3) @(negedge clk);
        write_cfg(8'h81);
        check_window(8'h81, 10, "R6 new period");

        // R2: disable mid-run
        write_cfg(8'h81);
        @(negedge clk);
        write_cfg(8'h01);
        check_low(30, "R2 disable mid-run");

        // R7: only unused bits set keeps it disabled
        write_cfg(8'h60);
        check_low(20, "R7 unused bits only");

        // R1: reset while running clears the control byte
        write_cfg(8'h80);
        check_window(8'h80, 3, "R5 period 1 before reset");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_low(30, "R1 reset while running");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule